// File: doc/BRIEF.md
# Oscillator Prescaler with Watchdog Timer

This block divides the oscillator clock through a chain of binary stages that runs all the time. When the top stage wraps, a sticky event flag is set. The flag can raise an interrupt request and can release the core from a hold state. Each of these two paths has its own enable input. Software clears the flag with a clear command, and that command also restarts the divider.

One of two divider stages feeds a small watchdog counter. A lower stage gives a fast watchdog and the top stage gives a slow one. The choice comes from one bit of a small write-only parameter register, which is changed with per-bit set and clear masks. Software must clear the watchdog often enough. If it does not, the counter overflows and the block issues a one-cycle system reset pulse, and the watchdog clears itself at the same time. A static enable input decides whether the watchdog runs at all.

Everything runs in the oscillator domain. The watchdog steps on a rising edge of the chosen stage, and that edge is detected synchronously, so no derived clock is used.

Top module: `presc_wdt`

## Requirements
- R1: While `rst_i` is high, the divider, the event flag, the watchdog count and the tap select are cleared. After reset, `evf_o`, `irq_o`, `hold_rel_o` and `sys_rst_o` are all 0.
- R2: The divider adds one on every clock. `evf_o` rises at the end of the clock in which the DIV_STAGES-bit count wraps from all ones. Counting edges from the last reset or clear edge, that is edge 2^DIV_STAGES. The flag then stays high until it is cleared.
- R3: `irq_o` is high exactly when `evf_o` and `ie0_i` are both high. `hold_rel_o` is high exactly when `evf_o` and `he0_i` are both high. Both are combinational.
- R4: A clock edge with `div_clr_i` or `evf_clr_i` high clears both the divider and `evf_o`. This clear wins over a wrap at the same edge, and the next flag comes 2^DIV_STAGES edges later.
- R5: Bit 3 of the parameter register picks the watchdog tap. 0 selects divider stage FAST_TAP and 1 selects stage SLOW_TAP (stage n is count bit n-1). An edge with `par_set_i[3]` high sets the bit and an edge with `par_clr_i[3]` high clears it; when both are high, clear wins. Bits 0 to 2 of both masks have no effect.
- R6: With the watchdog enabled, it steps one clock after each rising edge of the chosen stage T. The 2^WDT_STAGES-th step gives a `sys_rst_o` pulse, so with no clears the pulses follow edge 2^(T-1)+1+(2^WDT_STAGES-1)*2^T and then repeat every 2^(WDT_STAGES+T) edges.
- R7: An edge with `wdt_clr_i` high zeroes the watchdog count. At that edge it also blocks any pulse.
- R8: While `wdt_en_i` is low, the watchdog count is held at zero and `sys_rst_o` stays 0.
- R9: Each `sys_rst_o` pulse lasts one clock cycle, and the watchdog restarts from zero at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| div_clr_i | input | 1 | Clear strobe for the divider (also clears the event flag) |
| evf_clr_i | input | 1 | Clear strobe for event flag 0 (also restarts the divider) |
| wdt_clr_i | input | 1 | Clear strobe for the watchdog |
| par_set_i | input | 4 | Per-bit set mask for the parameter register |
| par_clr_i | input | 4 | Per-bit clear mask for the parameter register |
| wdt_en_i | input | 1 | Static watchdog enable |
| ie0_i | input | 1 | Interrupt enable for the event flag |
| he0_i | input | 1 | Hold-release enable for the event flag |
| evf_o | output | 1 | Sticky divider event flag |
| irq_o | output | 1 | Interrupt request |
| hold_rel_o | output | 1 | Hold release request |
| sys_rst_o | output | 1 | One-cycle system reset pulse from watchdog overflow |

## Verification
The bench runs a small configuration (6 divider stages, taps 3 and 6, a 2-stage watchdog) and checks every cycle against an arithmetic model. It aims at these corner cases:

- A divider clear on the very edge where the count wraps. A design that let the wrap win would set the flag anyway.
- Watchdog clears spaced so that the last step before overflow is cancelled. A design that dropped the clear would emit a reset pulse.
- A switch of the tap while the divider runs. A design that tracked only the selected stage's history would take an extra step, which moves every later pulse earlier.
- Writes that touch only the reserved bits, and set and clear of bit 3 in the same cycle. A design that decoded the wrong bit, or let set win, would run at the wrong rate.
- The cycle right after each pulse. A pulse that lasts two cycles fails there.

// File: rtl/presc_wdt_pkg.sv
package presc_wdt_pkg;

    // Width of the write-only parameter register and the bit that picks the tap
    localparam int PAR_BITS    = 4;
    localparam int TAP_SEL_BIT = 3;

    typedef enum logic {
        TAP_FAST = 1'b0,
        TAP_SLOW = 1'b1
    } tap_sel_e;

    // Synchronous rising-edge strobes of the two candidate divider stages
    typedef struct packed {
        logic slow;
        logic fast;
    } tap_pair_t;

    function automatic logic pick_edge(tap_pair_t edges, tap_sel_e sel);
        return (sel == TAP_SLOW) ? edges.slow : edges.fast;
    endfunction

    // Clear has priority over set for the same bit
    function automatic tap_sel_e next_sel(tap_sel_e cur, logic set_b, logic clr_b);
        if (clr_b) return TAP_FAST;
        if (set_b) return TAP_SLOW;
        return cur;
    endfunction

endpackage

// File: rtl/presc_par.sv
module presc_par
    import presc_wdt_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [PAR_BITS-1:0] set_i,
    input  logic [PAR_BITS-1:0] clr_i,
    output tap_sel_e            sel_o
);

    tap_sel_e sel_q;

    // Reserved positions are accepted but hold no state
    logic unused_rsvd;
    assign unused_rsvd = ^{set_i[TAP_SEL_BIT-1:0], clr_i[TAP_SEL_BIT-1:0]};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q <= TAP_FAST;
        end else begin
            sel_q <= next_sel(sel_q, set_i[TAP_SEL_BIT], clr_i[TAP_SEL_BIT]);
        end
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/presc_div.sv
module presc_div
    import presc_wdt_pkg::*;
#(
    parameter int STAGES   = 14,
    parameter int FAST_TAP = 10,
    parameter int SLOW_TAP = 14
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      restart_i,
    output logic      flag_o,
    output tap_pair_t rise_o
);

    logic [STAGES-1:0] q;
    logic [STAGES:0]   carry;
    tap_pair_t         now_t;
    tap_pair_t         prev_q;
    logic              flag_q;

    assign carry[0] = 1'b1;

    // Toggle chain: a stage flips when every stage below it is one
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic stage_q;
        always_ff @(posedge clk_i) begin
            if (rst_i || restart_i) begin
                stage_q <= 1'b0;
            end else if (carry[i]) begin
                stage_q <= ~stage_q;
            end
        end
        assign q[i]         = stage_q;
        assign carry[i + 1] = carry[i] & stage_q;
    end

    assign now_t.fast = q[FAST_TAP - 1];
    assign now_t.slow = q[SLOW_TAP - 1];

    // History kept for both taps so a tap switch never fakes an edge
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= '0;
        end else begin
            prev_q <= now_t;
        end
    end

    assign rise_o.fast = now_t.fast & ~prev_q.fast;
    assign rise_o.slow = now_t.slow & ~prev_q.slow;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            flag_q <= 1'b0;
        end else if (carry[STAGES]) begin
            flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/presc_wdog.sv
module presc_wdog #(
    parameter int STAGES = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic clr_i,
    input  logic tick_i,
    output logic ovf_o
);

    localparam logic [STAGES-1:0] TOP = {STAGES{1'b1}};

    logic [STAGES-1:0] cnt_q;
    logic              ovf_q;
    logic              wrap;

    assign wrap = tick_i && (cnt_q == TOP);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i || clr_i) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + STAGES'(tick_i);   // wraps to zero on overflow
            ovf_q <= wrap;
        end
    end

    assign ovf_o = ovf_q;

endmodule

// File: rtl/presc_wdt.sv
module presc_wdt
    import presc_wdt_pkg::*;
#(
    parameter int DIV_STAGES = 14,
    parameter int FAST_TAP   = 10,
    parameter int SLOW_TAP   = 14,
    parameter int WDT_STAGES = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                div_clr_i,
    input  logic                evf_clr_i,
    input  logic                wdt_clr_i,
    input  logic [PAR_BITS-1:0] par_set_i,
    input  logic [PAR_BITS-1:0] par_clr_i,
    input  logic                wdt_en_i,
    input  logic                ie0_i,
    input  logic                he0_i,
    output logic                evf_o,
    output logic                irq_o,
    output logic                hold_rel_o,
    output logic                sys_rst_o
);

    tap_sel_e  tap_sel;
    tap_pair_t tap_rise;
    logic      restart;
    logic      flag;

    assign restart = div_clr_i | evf_clr_i;

    presc_par u_par (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .set_i (par_set_i),
        .clr_i (par_clr_i),
        .sel_o (tap_sel)
    );

    presc_div #(
        .STAGES   (DIV_STAGES),
        .FAST_TAP (FAST_TAP),
        .SLOW_TAP (SLOW_TAP)
    ) u_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (restart),
        .flag_o    (flag),
        .rise_o    (tap_rise)
    );

    presc_wdog #(
        .STAGES (WDT_STAGES)
    ) u_wdog (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (wdt_en_i),
        .clr_i  (wdt_clr_i),
        .tick_i (pick_edge(tap_rise, tap_sel)),
        .ovf_o  (sys_rst_o)
    );

    assign evf_o      = flag;
    assign irq_o      = flag & ie0_i;
    assign hold_rel_o = flag & he0_i;

endmodule

// File: rtl/presc_wdt_chk.sv
module presc_wdt_chk (
    input logic clk_i,
    input logic rst_i,
    input logic div_clr_i,
    input logic evf_clr_i,
    input logic wdt_clr_i,
    input logic wdt_en_i,
    input logic ie0_i,
    input logic he0_i,
    input logic evf_o,
    input logic irq_o,
    input logic hold_rel_o,
    input logic sys_rst_o
);

    p_reset_state_r1: assert property (@(posedge clk_i)
        rst_i |=> (!evf_o && !sys_rst_o));

    p_flag_sticky_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (evf_o && !div_clr_i && !evf_clr_i) |=> evf_o);

    p_irq_gate_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (evf_o && ie0_i));

    p_hold_gate_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_rel_o |-> (evf_o && he0_i));

    p_clear_wins_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (div_clr_i || evf_clr_i) |=> !evf_o);

    p_wd_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_clr_i |=> !sys_rst_o);

    p_wd_off_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !wdt_en_i |=> !sys_rst_o);

    p_pulse_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        sys_rst_o |=> !sys_rst_o);

endmodule

bind presc_wdt presc_wdt_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .div_clr_i  (div_clr_i),
    .evf_clr_i  (evf_clr_i),
    .wdt_clr_i  (wdt_clr_i),
    .wdt_en_i   (wdt_en_i),
    .ie0_i      (ie0_i),
    .he0_i      (he0_i),
    .evf_o      (evf_o),
    .irq_o      (irq_o),
    .hold_rel_o (hold_rel_o),
    .sys_rst_o  (sys_rst_o)
);

// File: tb/presc_wdt_test.sv
module presc_wdt_test;

    localparam int N  = 6;
    localparam int FT = 3;
    localparam int ST = 6;
    localparam int WS = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dclr = 1'b0, eclr = 1'b0, wclr = 1'b0;
    logic [3:0] pset = '0, pclr = '0;
    logic       en = 1'b1, ie = 1'b0, he = 1'b0;
    logic       evf, irq, hold, srst;

    int checks = 0;
    int fails  = 0;

    // model state
    int k = 0;
    int wcnt = 0;
    bit m_evf = 0;
    bit m_sel = 0;
    bit m_rst = 0;

    always #2.5 clk = ~clk;

    presc_wdt #(
        .DIV_STAGES (N),
        .FAST_TAP   (FT),
        .SLOW_TAP   (ST),
        .WDT_STAGES (WS)
    ) uut (
        .clk_i (clk), .rst_i (rst),
        .div_clr_i (dclr), .evf_clr_i (eclr), .wdt_clr_i (wclr),
        .par_set_i (pset), .par_clr_i (pclr), .wdt_en_i (en),
        .ie0_i (ie), .he0_i (he),
        .evf_o (evf), .irq_o (irq), .hold_rel_o (hold), .sys_rst_o (srst)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d (k=%0d)", req, what, act, exp, k);
        end
    endtask

    function automatic bit tick_at(int kold, bit sel);
        int t = sel ? ST : FT;
        int h = 1 << (t - 1);
        int p = 1 << t;
        return (kold >= h) && (((kold - h) % p) == 0);
    endfunction

    task automatic do_reset(bit enable);
        en = enable; rst = 1'b1;
        dclr = 0; eclr = 0; wclr = 0; pset = '0; pclr = '0;
        ie = 1'b1; he = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "evf", evf, 0);
        chk("R1", "sys_rst", srst, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "hold", hold, 0);
        rst = 1'b0;
        k = 0; wcnt = 0; m_evf = 0; m_sel = 0; m_rst = 0;
    endtask

    // One clock with the given strobes; flag and pulse checked after the edge
    task automatic step(bit dc, bit ec, bit wc, logic [3:0] ps, logic [3:0] pc,
                        string rq_evf, string rq_rst);
        bit tick;
        bit prev_rst = m_rst;
        dclr = dc; eclr = ec; wclr = wc; pset = ps; pclr = pc;
        @(posedge clk);
        tick  = tick_at(k, m_sel);
        m_rst = 0;
        if (!en || wc) wcnt = 0;
        else if (tick) begin
            if (wcnt == (1 << WS) - 1) begin m_rst = 1; wcnt = 0; end
            else wcnt++;
        end
        if (dc || ec) begin m_evf = 0; k = 0; end
        else begin
            if ((k % (1 << N)) == (1 << N) - 1) m_evf = 1;
            k++;
        end
        if (pc[3]) m_sel = 0; else if (ps[3]) m_sel = 1;
        @(negedge clk);
        dclr = 0; eclr = 0; wclr = 0; pset = '0; pclr = '0;
        chk(rq_evf, "evf", evf, int'(m_evf));
        chk(prev_rst ? "R9" : rq_rst, "sys_rst", srst, int'(m_rst));
        chk("R3", "irq", irq, int'(m_evf & ie));
        chk("R3", "hold", hold, int'(m_evf & he));
    endtask

    task automatic run(int n, string rq_evf, string rq_rst);
        for (int i = 0; i < n; i++) begin
            ie = i[0]; he = i[1];
            step(0, 0, 0, '0, '0, rq_evf, rq_rst);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1, R2, R3, R6: fast tap, free run
        do_reset(1'b1);
        run(140, "R2", "R6");

        // R4: event flag clear restarts divider
        step(0, 1, 0, '0, '0, "R4", "R6");
        run(70, "R4", "R6");

        // R4: divider clear on the wrap edge must win
        while ((k % (1 << N)) != (1 << N) - 1) step(0, 0, 0, '0, '0, "R4", "R6");
        step(1, 0, 0, '0, '0, "R4", "R6");
        run(10, "R4", "R6");

        // R7: frequent watchdog clears keep the pulse away
        for (int j = 0; j < 12; j++) begin
            step(0, 0, 1, '0, '0, "R2", "R7");
            run(19, "R2", "R7");
        end
        run(40, "R2", "R7");

        // R5: slow tap selected through bit 3
        do_reset(1'b1);
        step(0, 0, 0, 4'b1000, '0, "R2", "R5");
        run(560, "R2", "R5");

        // R5: reserved bits only leave the fast tap in place
        do_reset(1'b1);
        step(0, 0, 0, 4'b0111, 4'b0000, "R2", "R5");
        run(70, "R2", "R5");

        // R5: set and clear together, clear wins
        do_reset(1'b1);
        step(0, 0, 0, 4'b1000, 4'b1000, "R2", "R5");
        run(70, "R2", "R5");

        // R5: switch from slow to fast while running
        do_reset(1'b1);
        step(0, 0, 0, 4'b1000, '0, "R2", "R5");
        run(45, "R2", "R5");
        step(0, 0, 0, '0, 4'b1000, "R2", "R5");
        run(100, "R2", "R5");

        // R8: watchdog disabled
        do_reset(1'b0);
        run(300, "R2", "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule